// File: doc/BRIEF.md
# Channel-Status and User-Data Collector

This block sits behind a biphase-mark line decoder in a digital audio receiver. Each decoded subframe brings one channel-status bit and one user bit. The collector gathers these bits into words for the host, so the host does not have to handle single bits. Channel-status bits are assembled separately for the two channels of a frame. When a full word is complete, the pair is compared with the pair the host can already see. The visible words are replaced, and a ready flag is raised, only if something changed. A host that polls or takes an interrupt on that flag therefore reads channel status only when it has new content. The channel-status path has no request line for a transfer engine.

User bits from both channels are interleaved into one word that completes every sixteen frames. The completed word is presented with a ready flag. If the host has not taken the previous word in time, the new word replaces it and an overrun flag records the loss.

The subframe input is a valid/ready stream. The collector never applies back-pressure: `sf_ready` is high in every cycle after reset, and a subframe is consumed on each clock edge where `sf_valid` is high. On the host side, each flag acts as a valid signal. The matching ready pin is the read strobe, and the handshake completes on an edge where both are high. The held word stays stable between completions, whatever the host does.

Top module: `csud_collector`

## Requirements
- R1: `sf_ready` is 1 in every cycle after reset, so every subframe presented with `sf_valid` high is consumed on that clock edge.
- R2: After reset, or after `rx_en` has been low, consumed subframes have no effect until one arrives with `sf_blk` = 1. That subframe is channel A (index 0) of frame 0, and later subframes alternate A, B, A, B.
- R3: The channel-status bit of channel c in frame k (counted from the last block start) is placed at bit (k mod 30) of that channel's word. A word pair completes on the channel B subframe of a frame whose index mod 30 is 29.
- R4: On completion, if either assembled word differs from the held words `cs_word0`/`cs_word1`, both held words are replaced and `cs_valid` is 1 from the next cycle. If both match, the held words and `cs_valid` are unchanged.
- R5: `cs_valid` clears after an edge where `cs_valid` and `cs_ready` are both 1, unless a change completes on that same edge. In that case it stays 1.
- R6: The user bit of channel c in frame k is placed at `ud_word` bit 2*(k mod 16)+c. On the channel B subframe of a frame whose index mod 16 is 15, `ud_word` takes the new word and `ud_valid` becomes 1. `ud_word` changes at no other time.
- R7: If a user word completes while `ud_valid` is 1 and `ud_ready` is 0, the word is still overwritten and `ud_ovr` becomes 1. A handshake (`ud_valid` and `ud_ready` both 1, with no completion on that edge) clears both `ud_valid` and `ud_ovr`.
- R8: While `rx_en` is 0, frame and channel tracking is cleared and synchronisation is lost. The held words and all flags keep their values, and the host handshakes still work.
- R9: A subframe with `sf_blk` = 1 that arrives in mid-word restarts both the 30-frame count and the 16-frame count at frame 0, so the partly assembled bits are discarded.
- R10: Reset (`rst_n` low) clears the held words and the flags `cs_valid`, `ud_valid` and `ud_ovr` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receiver run enable; low puts the collector into idle |
| sf_valid | input | 1 | A decoded subframe is present |
| sf_ready | output | 1 | Collector accepts the subframe (always 1) |
| sf_blk | input | 1 | Subframe carries the block-start preamble |
| sf_cs | input | 1 | Channel-status bit of the subframe |
| sf_ud | input | 1 | User bit of the subframe |
| cs_valid | output | 1 | Changed channel-status words are waiting |
| cs_ready | input | 1 | Host read strobe for channel status |
| cs_word0 | output | 30 | Held channel-status word, channel A |
| cs_word1 | output | 30 | Held channel-status word, channel B |
| ud_valid | output | 1 | A completed user-data word is waiting |
| ud_ready | input | 1 | Host read strobe for user data |
| ud_word | output | 32 | Held user-data word |
| ud_ovr | output | 1 | A user word was overwritten before it was read |

## Verification
The bench sends subframes before any block start and again after an idle period. A design that does not wait for synchronisation would fill words from misaligned bits and raise flags the model does not expect. It repeats an unchanged channel-status pattern over a whole block, where a design that forgets the compare would raise `cs_valid` again. It also alternates the pattern word by word while polling, so that reads land on the same edge as completions and an inverted set/clear priority shows up. It restarts a block in mid-word, which exposes any counter that ignores the restart through a mixed word. It lets user words pile up unread, and then checks that the overwrite, the overrun flag and its clearing on a read all match the model.

// File: rtl/csud_pkg.sv
package csud_pkg;
  localparam int unsigned CH_NUM = 2;

  typedef enum logic {
    CH_A = 1'b0,
    CH_B = 1'b1
  } chan_e;
endpackage

// File: rtl/csud_seq.sv
module csud_seq
  import csud_pkg::*;
#(
  parameter int unsigned CS_BITS   = 30,
  parameter int unsigned UD_FRAMES = 16
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  rx_en,
  input  logic  sf_fire,
  input  logic  sf_blk,
  output logic  take,
  output chan_e take_ch,
  output logic  cs_last,
  output logic  ud_last
);
  localparam int unsigned CSW = (CS_BITS > 1) ? $clog2(CS_BITS) : 1;
  localparam int unsigned UDW = (UD_FRAMES > 1) ? $clog2(UD_FRAMES) : 1;
  localparam logic [CSW-1:0] CS_END = CSW'(CS_BITS - 1);
  localparam logic [UDW-1:0] UD_END = UDW'(UD_FRAMES - 1);

  logic           locked_q;
  chan_e          ch_q;
  logic [CSW-1:0] cs_idx_q;
  logic [UDW-1:0] ud_idx_q;
  logic [CSW-1:0] cs_eff;
  logic [UDW-1:0] ud_eff;

  always_comb begin
    take    = rx_en & sf_fire & (sf_blk | locked_q);
    take_ch = sf_blk ? CH_A : ch_q;
    cs_eff  = sf_blk ? '0 : cs_idx_q;
    ud_eff  = sf_blk ? '0 : ud_idx_q;
    cs_last = take & (take_ch == CH_B) & (cs_eff == CS_END);
    ud_last = take & (take_ch == CH_B) & (ud_eff == UD_END);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked_q <= 1'b0;
      ch_q     <= CH_A;
      cs_idx_q <= '0;
      ud_idx_q <= '0;
    end else if (!rx_en) begin
      locked_q <= 1'b0;
      ch_q     <= CH_A;
      cs_idx_q <= '0;
      ud_idx_q <= '0;
    end else if (take) begin
      locked_q <= 1'b1;
      if (take_ch == CH_A) begin
        ch_q     <= CH_B;
        cs_idx_q <= cs_eff;
        ud_idx_q <= ud_eff;
      end else begin
        ch_q     <= CH_A;
        cs_idx_q <= (cs_eff == CS_END) ? '0 : cs_eff + 1'b1;
        ud_idx_q <= (ud_eff == UD_END) ? '0 : ud_eff + 1'b1;
      end
    end
  end

  // R8
  idle_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> (!locked_q && ch_q == CH_A && cs_idx_q == '0 && ud_idx_q == '0));

  // R2
  ch_alternate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !sf_blk) |=> (ch_q != $past(ch_q)));

  // R9
  blk_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && sf_blk) |=> (ch_q == CH_B && cs_idx_q == '0 && ud_idx_q == '0));

  // R3
  cs_idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_idx_q <= CS_END);
endmodule

// File: rtl/csud_cs_collect.sv
module csud_cs_collect
  import csud_pkg::*;
#(
  parameter int unsigned CS_BITS = 30
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             take,
  input  chan_e                            take_ch,
  input  logic                             cs_last,
  input  logic                             cs_bit,
  input  logic                             cs_ready,
  output logic [CH_NUM-1:0][CS_BITS-1:0]   cs_held,
  output logic                             cs_valid
);
  logic [CH_NUM-1:0][CS_BITS-1:0] shift_q;
  logic [CH_NUM-1:0][CS_BITS-1:0] word_nx;
  logic                           differs;
  logic                           upd;

  for (genvar c = 0; c < CH_NUM; c++) begin : g_chan
    logic hit;
    assign hit = take & (take_ch == chan_e'(c));
    always_comb begin
      word_nx[c] = hit ? {cs_bit, shift_q[c][CS_BITS-1:1]} : shift_q[c];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) shift_q[c] <= '0;
      else if (hit) shift_q[c] <= word_nx[c];
    end
  end

  assign differs = (word_nx != cs_held);
  assign upd     = cs_last & differs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_held  <= '0;
      cs_valid <= 1'b0;
    end else begin
      if (upd) cs_held <= word_nx;
      if (upd) cs_valid <= 1'b1;
      else if (cs_valid && cs_ready) cs_valid <= 1'b0;
    end
  end

  // R4
  cs_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_valid) |-> $past(cs_last));

  // R4
  cs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_last |=> $stable(cs_held));

  // R5
  cs_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_valid && cs_ready && !cs_last) |=> !cs_valid);
endmodule

// File: rtl/csud_ud_collect.sv
module csud_ud_collect #(
  parameter int unsigned UD_FRAMES = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   take,
  input  logic                   ud_last,
  input  logic                   ud_bit,
  input  logic                   ud_ready,
  output logic [2*UD_FRAMES-1:0] ud_word,
  output logic                   ud_valid,
  output logic                   ud_ovr
);
  localparam int unsigned UD_W = 2 * UD_FRAMES;

  logic [UD_W-1:0] shift_q;
  logic [UD_W-1:0] shift_nx;
  logic            hs;

  assign shift_nx = {ud_bit, shift_q[UD_W-1:1]};
  assign hs       = ud_valid & ud_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q  <= '0;
      ud_word  <= '0;
      ud_valid <= 1'b0;
      ud_ovr   <= 1'b0;
    end else begin
      if (take) shift_q <= shift_nx;
      if (ud_last) begin
        ud_word  <= shift_nx;
        ud_valid <= 1'b1;
        if (ud_valid && !ud_ready) ud_ovr <= 1'b1;
        else if (hs) ud_ovr <= 1'b0;
      end else if (hs) begin
        ud_valid <= 1'b0;
        ud_ovr   <= 1'b0;
      end
    end
  end

  // R7
  ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ud_valid && !ud_ready && ud_last) |=> ud_ovr);

  // R6
  ud_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ud_last |=> $stable(ud_word));

  // R7
  ud_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && !ud_last) |=> (!ud_valid && !ud_ovr));

  // R6
  ud_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ud_valid) |-> $past(ud_last));
endmodule

// File: rtl/csud_collector.sv
module csud_collector
  import csud_pkg::*;
#(
  parameter int unsigned CS_BITS   = 30,
  parameter int unsigned UD_FRAMES = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   rx_en,
  input  logic                   sf_valid,
  output logic                   sf_ready,
  input  logic                   sf_blk,
  input  logic                   sf_cs,
  input  logic                   sf_ud,
  output logic                   cs_valid,
  input  logic                   cs_ready,
  output logic [CS_BITS-1:0]     cs_word0,
  output logic [CS_BITS-1:0]     cs_word1,
  output logic                   ud_valid,
  input  logic                   ud_ready,
  output logic [2*UD_FRAMES-1:0] ud_word,
  output logic                   ud_ovr
);
  logic                           take;
  chan_e                          take_ch;
  logic                           cs_last;
  logic                           ud_last;
  logic [CH_NUM-1:0][CS_BITS-1:0] cs_held;

  assign sf_ready = 1'b1;

  csud_seq #(
    .CS_BITS  (CS_BITS),
    .UD_FRAMES(UD_FRAMES)
  ) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .rx_en  (rx_en),
    .sf_fire(sf_valid & sf_ready),
    .sf_blk (sf_blk),
    .take   (take),
    .take_ch(take_ch),
    .cs_last(cs_last),
    .ud_last(ud_last)
  );

  csud_cs_collect #(
    .CS_BITS(CS_BITS)
  ) u_cs (
    .clk     (clk),
    .rst_n   (rst_n),
    .take    (take),
    .take_ch (take_ch),
    .cs_last (cs_last),
    .cs_bit  (sf_cs),
    .cs_ready(cs_ready),
    .cs_held (cs_held),
    .cs_valid(cs_valid)
  );

  csud_ud_collect #(
    .UD_FRAMES(UD_FRAMES)
  ) u_ud (
    .clk     (clk),
    .rst_n   (rst_n),
    .take    (take),
    .ud_last (ud_last),
    .ud_bit  (sf_ud),
    .ud_ready(ud_ready),
    .ud_word (ud_word),
    .ud_valid(ud_valid),
    .ud_ovr  (ud_ovr)
  );

  assign cs_word0 = cs_held[0];
  assign cs_word1 = cs_held[1];

  // R1
  ready_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sf_valid |-> sf_ready);
endmodule

// File: tb/test_csud_collector.sv
module test_csud_collector;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_en = 1'b0;
  logic        sf_valid = 1'b0;
  logic        sf_blk = 1'b0;
  logic        sf_cs = 1'b0;
  logic        sf_ud = 1'b0;
  logic        cs_ready = 1'b0;
  logic        ud_ready = 1'b0;
  logic        sf_ready;
  logic        cs_valid;
  logic [29:0] cs_word0;
  logic [29:0] cs_word1;
  logic        ud_valid;
  logic [31:0] ud_word;
  logic        ud_ovr;

  always #4 clk = ~clk;

  csud_collector i_csud_collector (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .sf_valid(sf_valid),
    .sf_ready(sf_ready), .sf_blk(sf_blk), .sf_cs(sf_cs), .sf_ud(sf_ud),
    .cs_valid(cs_valid), .cs_ready(cs_ready), .cs_word0(cs_word0),
    .cs_word1(cs_word1), .ud_valid(ud_valid), .ud_ready(ud_ready),
    .ud_word(ud_word), .ud_ovr(ud_ovr)
  );

  int nchk = 0;
  int nerr = 0;
  int cyc  = 0;
  int cs_mode = 0;
  int ud_mode = 0;

  // behavioural reference state
  bit          m_locked;
  int          m_ch;
  int          m_f;
  logic [29:0] m_asm [2];
  logic [29:0] m_held [2];
  logic [31:0] m_uasm;
  logic [31:0] m_uword;
  bit          m_csv, m_udv, m_ovr;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic bit rd(input int mode);
    return (mode == 1) || (mode == 2 && (cyc % 5) == 0);
  endfunction

  task automatic model(input bit en, v, blk, csb, udb, csr, udr);
    bit cs_hs, ud_hs, cs_set, ud_set, ovr_set;
    int ch, f;
    cs_hs = m_csv && csr;
    ud_hs = m_udv && udr;
    cs_set = 0; ud_set = 0; ovr_set = 0;
    if (en && v && (blk || m_locked)) begin
      if (blk) begin ch = 0; f = 0; end
      else begin ch = m_ch; f = m_f; end
      m_asm[ch][f % 30] = csb;
      m_uasm[2 * (f % 16) + ch] = udb;
      if (ch == 1 && (f % 30) == 29) begin
        if (m_asm[0] != m_held[0] || m_asm[1] != m_held[1]) begin
          m_held[0] = m_asm[0];
          m_held[1] = m_asm[1];
          cs_set = 1;
        end
      end
      if (ch == 1 && (f % 16) == 15) begin
        m_uword = m_uasm;
        ud_set = 1;
        if (m_udv && !udr) ovr_set = 1;
      end
      m_locked = 1;
      if (ch == 0) begin m_ch = 1; m_f = f; end
      else begin m_ch = 0; m_f = f + 1; end
    end
    if (!en) begin m_locked = 0; m_ch = 0; m_f = 0; end
    m_csv = cs_set ? 1'b1 : (cs_hs ? 1'b0 : m_csv);
    m_udv = ud_set ? 1'b1 : (ud_hs ? 1'b0 : m_udv);
    m_ovr = ovr_set ? 1'b1 : (ud_hs ? 1'b0 : m_ovr);
  endtask

  task automatic compare();
    chk("R1 sf_ready", 64'(sf_ready), 64'd1);
    chk("R4 cs_word0", 64'(cs_word0), 64'(m_held[0]));
    chk("R4 cs_word1", 64'(cs_word1), 64'(m_held[1]));
    chk("R5 cs_valid", 64'(cs_valid), 64'(m_csv));
    chk("R6 ud_word", 64'(ud_word), 64'(m_uword));
    chk("R6 ud_valid", 64'(ud_valid), 64'(m_udv));
    chk("R7 ud_ovr", 64'(ud_ovr), 64'(m_ovr));
  endtask

  task automatic step(input bit en, v, blk, csb, udb);
    bit csr, udr;
    csr = rd(cs_mode);
    udr = rd(ud_mode);
    rx_en = en; sf_valid = v; sf_blk = blk; sf_cs = csb; sf_ud = udb;
    cs_ready = csr; ud_ready = udr;
    @(posedge clk);
    model(en, v, blk, csb, udb, csr, udr);
    @(negedge clk);
    cyc++;
    compare();
  endtask

  task automatic frame(input int f, input bit blk, input logic [29:0] p0, input logic [29:0] p1,
                       input logic [31:0] up, input bit vary, input bit gap);
    bit flip;
    flip = vary && (((f / 30) % 2) == 1);
    step(1, 1, blk, p0[f % 30] ^ flip, up[2 * (f % 16)]);
    if (gap) step(1, 0, 0, 0, 0);
    step(1, 1, 0, p1[f % 30] ^ flip, up[2 * (f % 16) + 1]);
    if (gap) step(1, 0, 0, 0, 0);
  endtask

  task automatic block(input int nfr, input bit first_blk, input logic [29:0] p0,
                       input logic [29:0] p1, input logic [31:0] up, input bit vary, input bit gap);
    for (int f = 0; f < nfr; f++) frame(f, first_blk && f == 0, p0, p1, up, vary, gap);
  endtask

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk);
    nerr++;
    nchk++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    m_locked = 0; m_ch = 0; m_f = 0;
    m_asm[0] = '0; m_asm[1] = '0; m_held[0] = '0; m_held[1] = '0;
    m_uasm = '0; m_uword = '0; m_csv = 0; m_udv = 0; m_ovr = 0;
    repeat (3) @(negedge clk);
    // R10 reset values
    chk("R10 cs_valid", 64'(cs_valid), 64'd0);
    chk("R10 ud_valid", 64'(ud_valid), 64'd0);
    chk("R10 ud_ovr", 64'(ud_ovr), 64'd0);
    chk("R10 words", 64'(cs_word0 | cs_word1 | 30'(ud_word)), 64'd0);
    rst_n = 1'b1;
    step(1, 0, 0, 0, 0);

    // R2: no block start yet, everything ignored
    block(40, 0, 30'h3fff_ffff, 30'h2aaa_aaaa, 32'hffff_ffff, 0, 0);
    chk("R2 no cs before sync", 64'(cs_valid), 64'd0);
    chk("R2 no ud before sync", 64'(ud_valid), 64'd0);

    // first block, nothing read: ud overruns
    block(192, 1, 30'h1234_5678, 30'h0bad_cafe, 32'hc3a5_0f96, 0, 0);
    chk("R3 ch A bit placement", 64'(cs_word0), 64'(30'h1234_5678));
    chk("R3 ch B bit placement", 64'(cs_word1), 64'(30'h0bad_cafe));
    chk("R6 ud bit placement", 64'(ud_word), 64'hc3a5_0f96);
    chk("R7 overrun seen", 64'(ud_ovr), 64'd1);

    cs_mode = 1; ud_mode = 1;
    step(1, 0, 0, 0, 0);
    chk("R5 cs read clears", 64'(cs_valid), 64'd0);
    chk("R7 ud read clears ovr", 64'(ud_ovr), 64'd0);

    // same content again: no change indication
    cs_mode = 0; ud_mode = 2;
    block(192, 1, 30'h1234_5678, 30'h0bad_cafe, 32'h5a5a_1234, 0, 0);
    chk("R4 unchanged word raises nothing", 64'(cs_valid), 64'd0);

    // changing every word, polled reads collide with completions
    cs_mode = 2;
    block(192, 1, 30'h2468_ace0, 30'h1357_9bdf, 32'h0f0f_f0f0, 1, 1);
    cs_mode = 0;
    block(40, 1, 30'h0000_ffff, 30'h3fff_0000, 32'h8001_7ffe, 0, 1);
    chk("R4 changed word A", 64'(cs_word0), 64'(30'h0000_ffff));
    chk("R4 changed flag", 64'(cs_valid), 64'd1);

    // R9 restart in mid-word
    block(20, 1, 30'h1555_5555, 30'h0aaa_aaaa, 32'h1111_2222, 0, 0);
    block(30, 1, 30'h0f0f_0f0f, 30'h30f0_f0f0, 32'h9876_5432, 0, 0);
    chk("R9 restart word A", 64'(cs_word0), 64'(30'h0f0f_0f0f));
    chk("R9 restart word B", 64'(cs_word1), 64'(30'h30f0_f0f0));
    chk("R9 restart user word", 64'(ud_word), 64'h9876_5432);

    // R8 idle: sync lost, words and flags kept
    step(0, 1, 1, 1, 1);
    step(0, 1, 0, 1, 1);
    step(0, 0, 0, 0, 0);
    block(40, 0, 30'h3fff_ffff, 30'h3fff_ffff, 32'hffff_ffff, 0, 0);
    chk("R8 word kept through idle", 64'(cs_word0), 64'(30'h0f0f_0f0f));
    chk("R8 flag kept through idle", 64'(cs_valid), 64'd1);
    cs_mode = 1; ud_mode = 1;
    block(64, 1, 30'h2222_1111, 30'h0101_0101, 32'hdead_beef, 0, 0);
    chk("R8 resync after idle", 64'(ud_word), 64'hdead_beef);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule